// File: doc/BRIEF.md
# Sink Status and Control Register Bank

This block is the sink-side register bank of the HDMI status and control data channel. It sits behind a byte-level slave engine that has already decoded the bus: the engine presents each received address byte, each received data byte and each request for a byte to send. The bank replies with an address acknowledge and with read data. It keeps the source-written version and link configuration, and it keeps sixteen update flags that sink logic raises and the source clears. Sink status, scrambler status and error-counter bytes are plain inputs that the bank reads out. The link logic takes the decoded scrambling enable, bit-clock ratio, FRL rate and FFE level count straight from the outputs.

Inside a write transaction, the first data byte loads the register pointer. Each later byte is written at the pointer, and the pointer then steps by one. A read transaction starts at the current pointer and steps it after every byte. Each register can be written only if its direction allows a source write. Writes to other offsets are taken on the bus but change nothing. While the presence input is low, the bank does not answer its bus address at all.

Top module: `scdc_regfile`

## Requirements
- R1: An address byte with 7-bit address 0x54 is acknowledged (`hdr_ack_o` high in the same cycle as `hdr_vld_i`) when `present_i` is high. Any other address is not acknowledged.
- R2: While `present_i` is low, no address is acknowledged, `rd_vld_o` stays low and no host write changes any register.
- R3: The first data byte of a write transaction sets the pointer. Each later data byte is written at the pointer, which then increments. Each read request returns the byte at the pointer one cycle later on `rd_data_o` with `rd_vld_o` high, and then increments the pointer.
- R4: Offset 0x01 reads the SINK_VER parameter (default 0x01) and ignores writes. Offset 0x02 is written by the source, reads back and drives `src_version_o`.
- R5: Update flags bits 7:0 sit at offset 0x10 and bits 15:8 at offset 0x11. A high `upd_set_i` bit sets its flag. A host write of 1 to a flag bit clears it, and a written 0 leaves it unchanged.
- R6: If a set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R7: At offset 0x20, bit 0 drives `scramble_en_o` and bit 1 drives `clk_ratio_o` (0 means 1:10, 1 means 1:40). The upper bits read as 0.
- R8: At offset 0x31, bits 3:0 drive `frl_rate_o` and bits 7:4 drive `ffe_levels_o`. The byte reads back as written.
- R9: Offset 0x21 reads `scr_status_i` and offset 0x40 reads `status_flags_i`. Offsets 0x50+k read `err_cnt_i[8k+7:8k]`. Host writes to these offsets are ignored.
- R10: Undefined offsets read 0x00, and writes to them are ignored.
- R11: After reset, all source-written registers, all flags and `rd_data_o` are zero and `rd_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| present_i | input | 1 | Channel declared present |
| hdr_vld_i | input | 1 | Address byte received (pulse) |
| hdr_addr_i | input | 7 | Received 7-bit address |
| hdr_rd_i | input | 1 | Transaction is a read |
| hdr_ack_o | output | 1 | Address acknowledge |
| wr_vld_i | input | 1 | Data byte received (pulse) |
| wr_data_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Engine requests a byte to send (pulse) |
| rd_data_o | output | 8 | Byte to send |
| rd_vld_o | output | 1 | `rd_data_o` updated this cycle |
| stop_i | input | 1 | Transaction ended |
| upd_set_i | input | 16 | Update flag set events |
| scr_status_i | input | 8 | Scrambler status byte |
| status_flags_i | input | 8 | Lock and readiness status byte |
| err_cnt_i | input | 64 | Error-counter bytes |
| src_version_o | output | 8 | Source version |
| scramble_en_o | output | 1 | Scrambling enable |
| clk_ratio_o | output | 1 | Bit-clock ratio select |
| frl_rate_o | output | 4 | FRL rate code |
| ffe_levels_o | output | 4 | FFE level count |

## Verification
A flag raised by sink logic and a source write of 1 to that same flag can arrive in the same cycle. The bench provokes this by raising an `upd_set_i` bit on the very edge where a data byte with that bit set is written at offset 0x10. It then reads the flag back and expects it to still be 1. A later clear with no competing set shows that the write path was live on that edge.

// File: rtl/scdc_pkg.sv
package scdc_pkg;
   localparam logic [7:0] OFS_SINK_VER = 8'h01;
   localparam logic [7:0] OFS_SRC_VER  = 8'h02;
   localparam logic [7:0] OFS_UPD_LO   = 8'h10;
   localparam logic [7:0] OFS_UPD_HI   = 8'h11;
   localparam logic [7:0] OFS_TMDS     = 8'h20;
   localparam logic [7:0] OFS_SCR_ST   = 8'h21;
   localparam logic [7:0] OFS_LINKCFG  = 8'h31;
   localparam logic [7:0] OFS_STAT     = 8'h40;
   localparam logic [7:0] OFS_ERR_BASE = 8'h50;

   typedef struct packed {
      logic clk_ratio;
      logic scr_en;
   } tmds_cfg_t;

   typedef struct packed {
      logic [3:0] ffe;
      logic [3:0] frl;
   } link_cfg_t;
endpackage

// File: rtl/scdc_xact.sv
module scdc_xact #(
   parameter logic [6:0] SLV_ADDR = 7'h54
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       present_i,
   input  logic       hdr_vld_i,
   input  logic [6:0] hdr_addr_i,
   input  logic       hdr_rd_i,
   input  logic       wr_vld_i,
   input  logic [7:0] wr_data_i,
   input  logic       rd_req_i,
   input  logic       stop_i,
   output logic       hdr_ack_o,
   output logic       wr_stb_o,
   output logic [7:0] wr_ofs_o,
   output logic       rd_stb_o,
   output logic [7:0] ptr_o
);
   logic       sel_q, expect_ofs_q, match, sel;
   logic [7:0] ptr_q;

   assign match     = present_i && (hdr_addr_i == SLV_ADDR);
   assign sel       = sel_q && present_i;
   assign hdr_ack_o = hdr_vld_i && match;
   assign wr_stb_o  = wr_vld_i && sel && !expect_ofs_q;
   assign wr_ofs_o  = ptr_q;
   assign rd_stb_o  = rd_req_i && sel;
   assign ptr_o     = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q        <= 1'b0;
         expect_ofs_q <= 1'b0;
         ptr_q        <= '0;
      end else if (hdr_vld_i) begin
         sel_q        <= match;
         expect_ofs_q <= match && !hdr_rd_i;
      end else if (stop_i) begin
         sel_q        <= 1'b0;
         expect_ofs_q <= 1'b0;
      end else if (wr_vld_i && sel) begin
         if (expect_ofs_q) begin
            ptr_q        <= wr_data_i;
            expect_ofs_q <= 1'b0;
         end else begin
            ptr_q <= ptr_q + 8'd1;
         end
      end else if (rd_stb_o) begin
         ptr_q <= ptr_q + 8'd1;
      end
   end

   // R3: a read by itself advances the pointer by exactly one
   a_r3_rd_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_o && !hdr_vld_i && !stop_i && !wr_vld_i) |=> (ptr_o == $past(ptr_o) + 8'd1));
   // R1: the acknowledge is only ever given in an address cycle
   a_r1_ack_only_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_ack_o |-> hdr_vld_i);
endmodule

// File: rtl/scdc_upd_flags.sv
module scdc_upd_flags #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic [NBITS-1:0] clr_i,
   output logic [NBITS-1:0] flags_o
);
   if (NBITS < 1) begin : g_bad_width
      $error("scdc_upd_flags: NBITS must be positive");
   end

   for (genvar b = 0; b < NBITS; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flags_o[b] <= 1'b0;
         else if (set_i[b])  flags_o[b] <= 1'b1;
         else if (clr_i[b])  flags_o[b] <= 1'b0;
      end

      // R6: a set event always leaves the flag high
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> flags_o[b]);
      // R5: a clear without a competing set drops the flag
      a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !flags_o[b]);
   end
endmodule

// File: rtl/scdc_rdmux.sv
module scdc_rdmux
   import scdc_pkg::*;
#(
   parameter logic [7:0] SINK_VER  = 8'h01,
   parameter int         ERR_BYTES = 8
) (
   input  logic [7:0]             ofs_i,
   input  logic [7:0]             src_ver_i,
   input  logic [15:0]            flags_i,
   input  tmds_cfg_t              tmds_i,
   input  link_cfg_t              link_i,
   input  logic [7:0]             scr_status_i,
   input  logic [7:0]             status_flags_i,
   input  logic [ERR_BYTES*8-1:0] err_cnt_i,
   output logic [7:0]             data_o
);
   always_comb begin
      data_o = 8'h00;
      case (ofs_i)
         OFS_SINK_VER: data_o = SINK_VER;
         OFS_SRC_VER:  data_o = src_ver_i;
         OFS_UPD_LO:   data_o = flags_i[7:0];
         OFS_UPD_HI:   data_o = flags_i[15:8];
         OFS_TMDS:     data_o = {6'b0, tmds_i};
         OFS_SCR_ST:   data_o = scr_status_i;
         OFS_LINKCFG:  data_o = link_i;
         OFS_STAT:     data_o = status_flags_i;
         default: begin
            for (int k = 0; k < ERR_BYTES; k++) begin
               if (ofs_i == OFS_ERR_BASE + 8'(k)) data_o = err_cnt_i[8*k +: 8];
            end
         end
      endcase
   end
endmodule

// File: rtl/scdc_regfile.sv
module scdc_regfile
   import scdc_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR  = 7'h54,
   parameter logic [7:0] SINK_VER  = 8'h01,
   parameter int         ERR_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   present_i,
   input  logic                   hdr_vld_i,
   input  logic [6:0]             hdr_addr_i,
   input  logic                   hdr_rd_i,
   output logic                   hdr_ack_o,
   input  logic                   wr_vld_i,
   input  logic [7:0]             wr_data_i,
   input  logic                   rd_req_i,
   output logic [7:0]             rd_data_o,
   output logic                   rd_vld_o,
   input  logic                   stop_i,
   input  logic [15:0]            upd_set_i,
   input  logic [7:0]             scr_status_i,
   input  logic [7:0]             status_flags_i,
   input  logic [ERR_BYTES*8-1:0] err_cnt_i,
   output logic [7:0]             src_version_o,
   output logic                   scramble_en_o,
   output logic                   clk_ratio_o,
   output logic [3:0]             frl_rate_o,
   output logic [3:0]             ffe_levels_o
);
   localparam int UPD_BITS = 16;

   if (ERR_BYTES < 1 || ERR_BYTES > 8) begin : g_bad_err
      $error("scdc_regfile: ERR_BYTES must be 1..8");
   end

   logic        wr_stb, rd_stb;
   logic [7:0]  wr_ofs, ptr, rd_byte;
   logic [UPD_BITS-1:0] clr_mask, flags;
   logic [7:0]  src_ver_q;
   tmds_cfg_t   tmds_q;
   link_cfg_t   link_q;

   scdc_xact #(.SLV_ADDR(SLV_ADDR)) u_xact (
      .clk(clk), .rst_n(rst_n), .present_i(present_i),
      .hdr_vld_i(hdr_vld_i), .hdr_addr_i(hdr_addr_i), .hdr_rd_i(hdr_rd_i),
      .wr_vld_i(wr_vld_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
      .stop_i(stop_i), .hdr_ack_o(hdr_ack_o), .wr_stb_o(wr_stb),
      .wr_ofs_o(wr_ofs), .rd_stb_o(rd_stb), .ptr_o(ptr));

   always_comb begin
      clr_mask = '0;
      if (wr_stb && wr_ofs == OFS_UPD_LO) clr_mask[7:0]  = wr_data_i;
      if (wr_stb && wr_ofs == OFS_UPD_HI) clr_mask[15:8] = wr_data_i;
   end

   scdc_upd_flags #(.NBITS(UPD_BITS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(upd_set_i), .clr_i(clr_mask), .flags_o(flags));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_ver_q <= '0;
         tmds_q    <= '0;
         link_q    <= '0;
      end else if (wr_stb) begin
         case (wr_ofs)
            OFS_SRC_VER: src_ver_q <= wr_data_i;
            OFS_TMDS:    tmds_q    <= wr_data_i[1:0];
            OFS_LINKCFG: link_q    <= wr_data_i;
            default: ;
         endcase
      end
   end

   scdc_rdmux #(.SINK_VER(SINK_VER), .ERR_BYTES(ERR_BYTES)) u_rdmux (
      .ofs_i(ptr), .src_ver_i(src_ver_q), .flags_i(flags), .tmds_i(tmds_q),
      .link_i(link_q), .scr_status_i(scr_status_i), .status_flags_i(status_flags_i),
      .err_cnt_i(err_cnt_i), .data_o(rd_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= '0;
         rd_vld_o  <= 1'b0;
      end else begin
         rd_vld_o <= rd_stb;
         if (rd_stb) rd_data_o <= rd_byte;
      end
   end

   assign src_version_o = src_ver_q;
   assign scramble_en_o = tmds_q.scr_en;
   assign clk_ratio_o   = tmds_q.clk_ratio;
   assign frl_rate_o    = link_q.frl;
   assign ffe_levels_o  = link_q.ffe;

   // R2: an absent channel never acknowledges
   a_r2_silent_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !present_i |-> !hdr_ack_o);
   // R2: an absent channel never returns read data
   a_r2_silent_read: assert property (@(posedge clk) disable iff (!rst_n)
      !present_i |=> !rd_vld_o);
   // R7: TMDS outputs only move on a host write
   a_r7_tmds_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld_i |=> $stable({scramble_en_o, clk_ratio_o}));
   // R8: link configuration only moves on a host write
   a_r8_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld_i |=> $stable({frl_rate_o, ffe_levels_o}));
   // R4: source version only moves on a host write
   a_r4_ver_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld_i |=> $stable(src_version_o));
endmodule

// File: tb/scdc_regfile_tb.sv
module scdc_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        present_i = 1'b1;
   logic        hdr_vld_i = 1'b0;
   logic [6:0]  hdr_addr_i = '0;
   logic        hdr_rd_i = 1'b0;
   logic        hdr_ack_o;
   logic        wr_vld_i = 1'b0;
   logic [7:0]  wr_data_i = '0;
   logic        rd_req_i = 1'b0;
   logic [7:0]  rd_data_o;
   logic        rd_vld_o;
   logic        stop_i = 1'b0;
   logic [15:0] upd_set_i = '0;
   logic [7:0]  scr_status_i = 8'hC3;
   logic [7:0]  status_flags_i = 8'h5A;
   logic [63:0] err_cnt_i = 64'h8877_6655_4433_2211;
   logic [7:0]  src_version_o;
   logic        scramble_en_o, clk_ratio_o;
   logic [3:0]  frl_rate_o, ffe_levels_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   scdc_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .present_i(present_i), .hdr_vld_i(hdr_vld_i),
      .hdr_addr_i(hdr_addr_i), .hdr_rd_i(hdr_rd_i), .hdr_ack_o(hdr_ack_o),
      .wr_vld_i(wr_vld_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
      .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .stop_i(stop_i),
      .upd_set_i(upd_set_i), .scr_status_i(scr_status_i),
      .status_flags_i(status_flags_i), .err_cnt_i(err_cnt_i),
      .src_version_o(src_version_o), .scramble_en_o(scramble_en_o),
      .clk_ratio_o(clk_ratio_o), .frl_rate_o(frl_rate_o), .ffe_levels_o(ffe_levels_o));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hdr(input logic [6:0] a, input logic rd, output logic ack);
      @(negedge clk);
      hdr_vld_i = 1'b1; hdr_addr_i = a; hdr_rd_i = rd;
      #1 ack = hdr_ack_o;
      @(negedge clk);
      hdr_vld_i = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] d);
      @(negedge clk);
      wr_vld_i = 1'b1; wr_data_i = d;
      @(negedge clk);
      wr_vld_i = 1'b0;
   endtask

   task automatic stop();
      @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
   endtask

   task automatic rbyte(output logic [7:0] d, output logic v);
      @(negedge clk);
      rd_req_i = 1'b1;
      @(negedge clk);
      rd_req_i = 1'b0;
      d = rd_data_o; v = rd_vld_o;
   endtask

   task automatic wr_seq(input logic [7:0] ofs, input logic [7:0] d);
      logic a;
      hdr(7'h54, 1'b0, a); wbyte(ofs); wbyte(d); stop();
   endtask

   task automatic rd_at(input string req, input logic [7:0] ofs, input logic [7:0] exp);
      logic a, v;
      logic [7:0] d;
      hdr(7'h54, 1'b0, a); wbyte(ofs); stop();
      hdr(7'h54, 1'b1, a); rbyte(d, v); stop();
      chk({req, " valid"}, 16'(v), 16'd1);
      chk(req, 16'(d), 16'(exp));
   endtask

   task automatic t_reset();
      chk("R11 rd_vld", 16'(rd_vld_o), 16'd0);
      chk("R11 rd_data", 16'(rd_data_o), 16'd0);
      chk("R11 outputs", {src_version_o, scramble_en_o, clk_ratio_o, frl_rate_o, ffe_levels_o[1:0]}, 16'd0);
      rd_at("R11 flags lo", 8'h10, 8'h00);
   endtask

   task automatic t_addr();
      logic a;
      hdr(7'h50, 1'b0, a); chk("R1 wrong addr", 16'(a), 16'd0); stop();
      hdr(7'h54, 1'b0, a); chk("R1 own addr", 16'(a), 16'd1); stop();
   endtask

   task automatic t_version();
      wr_seq(8'h02, 8'h21);
      chk("R4 src_version_o", 16'(src_version_o), 16'h21);
      rd_at("R4 src ver readback", 8'h02, 8'h21);
      wr_seq(8'h01, 8'hEE);
      rd_at("R4 sink ver", 8'h01, 8'h01);
   endtask

   task automatic t_link();
      logic a, v;
      logic [7:0] d;
      wr_seq(8'h20, 8'hFF);
      chk("R7 scramble", 16'(scramble_en_o), 16'd1);
      chk("R7 ratio", 16'(clk_ratio_o), 16'd1);
      rd_at("R7 tmds readback", 8'h20, 8'h03);
      wr_seq(8'h20, 8'h02);
      chk("R7 bits split", {scramble_en_o, clk_ratio_o}, 16'b01);
      hdr(7'h54, 1'b0, a); wbyte(8'h30); wbyte(8'h77); wbyte(8'h3C); stop();
      chk("R8 frl", 16'(frl_rate_o), 16'hC);
      chk("R8 ffe", 16'(ffe_levels_o), 16'h3);
      hdr(7'h54, 1'b0, a); wbyte(8'h30); stop();
      hdr(7'h54, 1'b1, a);
      rbyte(d, v); chk("R10 undefined 0x30", 16'(d), 16'h00);
      rbyte(d, v); chk("R3 autoinc read 0x31", 16'(d), 16'h3C);
      stop();
   endtask

   task automatic t_status();
      logic a, v;
      logic [7:0] d;
      rd_at("R9 scr status", 8'h21, 8'hC3);
      rd_at("R9 status flags", 8'h40, 8'h5A);
      hdr(7'h54, 1'b0, a); wbyte(8'h50); stop();
      hdr(7'h54, 1'b1, a);
      for (int k = 0; k < 8; k++) begin
         rbyte(d, v);
         chk($sformatf("R9 err byte %0d", k), 16'(d), 16'(err_cnt_i[8*k +: 8]));
      end
      stop();
      wr_seq(8'h21, 8'h00);
      rd_at("R9 write ignored", 8'h21, 8'hC3);
   endtask

   task automatic t_undef();
      rd_at("R10 read 0x7F", 8'h7F, 8'h00);
      wr_seq(8'h7F, 8'hFF);
      rd_at("R10 write ignored", 8'h7F, 8'h00);
      chk("R10 no side effect", {src_version_o, scramble_en_o, clk_ratio_o, 6'b0}, {8'h21, 2'b01, 6'b0});
   endtask

   task automatic t_flags();
      logic a;
      @(negedge clk); upd_set_i = 16'h8001;
      @(negedge clk); upd_set_i = 16'h0000;
      rd_at("R5 flags lo set", 8'h10, 8'h01);
      rd_at("R5 flags hi set", 8'h11, 8'h80);
      wr_seq(8'h10, 8'h00);
      rd_at("R5 write 0 keeps", 8'h10, 8'h01);
      wr_seq(8'h10, 8'h01);
      rd_at("R5 write 1 clears", 8'h10, 8'h00);
      wr_seq(8'h11, 8'h80);
      rd_at("R5 hi clears", 8'h11, 8'h00);
   endtask

   task automatic t_collide();
      logic a;
      hdr(7'h54, 1'b0, a); wbyte(8'h10);
      @(negedge clk);
      wr_vld_i = 1'b1; wr_data_i = 8'h04; upd_set_i = 16'h0004;
      @(negedge clk);
      wr_vld_i = 1'b0; upd_set_i = 16'h0000;
      stop();
      rd_at("R6 set wins", 8'h10, 8'h04);
      wr_seq(8'h10, 8'h04);
      rd_at("R6 later clear", 8'h10, 8'h00);
   endtask

   task automatic t_absent();
      logic a, v;
      logic [7:0] d;
      present_i = 1'b0;
      hdr(7'h54, 1'b0, a); chk("R2 no ack", 16'(a), 16'd0);
      wbyte(8'h02); wbyte(8'h99); stop();
      chk("R2 no write", 16'(src_version_o), 16'h21);
      hdr(7'h54, 1'b1, a); rbyte(d, v); stop();
      chk("R2 no read", 16'(v), 16'd0);
      present_i = 1'b1;
      rd_at("R2 reg intact", 8'h02, 8'h21);
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_version();
      t_link();
      t_status();
      t_undef();
      t_flags();
      t_collide();
      t_absent();
      finish_up();
   end
endmodule